// File: doc/BRIEF.md
# Clock Output Enable and Synchronous Gating Controller

This block sits between one shared source clock and a bank of clock outputs. It decides for every output whether the pad is driven or left at high impedance, and what clock data value it carries. Each output has its own static setting: a two-bit enable mode, a polarity bit and a bit that says whether the output obeys the gate input. A chip-wide high-impedance override takes precedence over all of these settings. When the override is active the feedback path is also switched off, and the block raises a loss-of-lock flag.

Output enables are decoded combinationally from the enable inputs and the configuration. The active-low gate input goes through a two-flop synchronizer. Each participating output then applies the decision only on a falling edge of the source clock. As a result, a true-polarity output stops only after a complete high phase and starts again at the beginning of a full high phase, so it never produces a runt pulse. An inverted output is the complement of the gated true clock, so while it is gated it rests high.

Top module: `clkout_ctrl`

## Requirements
- R1: While `glb_hiz_i` is 1, every bit of `drv_en_o` is 0, whatever the modes and secondary enables are.
- R2: An output whose mode is 2'b00 (off) has its `drv_en_o` bit at 0 in every case.
- R3: With `glb_hiz_i` at 0, an output whose mode is 2'b01 (on) has its `drv_en_o` bit at 1.
- R4: With `glb_hiz_i` at 0, an output whose mode is 2'b10 has `drv_en_o` equal to the inverse of `sec_a_n_i`.
- R5: With `glb_hiz_i` at 0, an output whose mode is 2'b11 has `drv_en_o` equal to the inverse of `sec_b_n_i`.
- R6: `lock_loss_o` is 1 exactly while `glb_hiz_i` is 1.
- R7: Gating never changes `drv_en_o`. While a participating output (`cfg_gate_en_i` bit 1) is gated, it rests at 0 if `cfg_inv_i` is 0 and at 1 if `cfg_inv_i` is 1.
- R8: A change on `gate_n_i` is captured on the next two rising edges and reaches the data path at the falling edge that follows the second one. A stopping output therefore completes its current high phase, and a restarting output first rises on a rising edge of the source clock.
- R9: A non-participating output (`cfg_gate_en_i` bit 0) carries the source clock when `cfg_inv_i` is 0 and its complement when it is 1, whatever `gate_n_i` is.
- R10: While `rst` is 1, `drv_en_o` is all 0 and every output sits at its gated level. The synchronizer resets to the gated state, so after release participating outputs start only once the gate input has been seen high through the synchronizer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_src | input | 1 | Shared source clock, also the block clock |
| rst | input | 1 | Synchronous active-high reset |
| glb_hiz_i | input | 1 | Global override, 1 forces all outputs to high impedance |
| sec_a_n_i | input | 1 | Secondary enable A, active low |
| sec_b_n_i | input | 1 | Secondary enable B, active low |
| gate_n_i | input | 1 | Synchronous gate request, active low |
| cfg_mode_i | input | 2*N_OUT | Per-output enable mode, output i at bits [2i+1:2i] |
| cfg_inv_i | input | N_OUT | Per-output polarity, 1 = inverted |
| cfg_gate_en_i | input | N_OUT | Per-output gate participation, 1 = obeys gate |
| clk_o | output | N_OUT | Per-output clock data value |
| drv_en_o | output | N_OUT | Per-output driver enable, 0 = high impedance |
| lock_loss_o | output | 1 | Feedback driver off, lock would be lost |

## Verification
The enable decode and the synchronous gate can both act on the same output in the same cycle. The bench provokes this by raising the global override while a participating output is held at its gated level, and then dropping the override again. It then checks that the driver enables fall to zero and the loss-of-lock flag rises at once, while the gated data levels stay as they are during the high phase. After the override is removed, the enables return without disturbing the gate state.

// File: rtl/clkoe_pkg.sv
package clkoe_pkg;

    typedef enum logic [1:0] {
        OE_OFF   = 2'b00,
        OE_ON    = 2'b01,
        OE_SEC_A = 2'b10,
        OE_SEC_B = 2'b11
    } oe_mode_e;

    typedef struct packed {
        logic run;
    } slice_state_t;

endpackage

// File: rtl/gate_synchronizer.sv
module gate_synchronizer #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_i,
    output logic sync_o
);
    typedef struct packed {
        logic [SYNC_STAGES-1:0] chain;
    } sync_state_t;

    sync_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d.chain = '0;
        end else if (SYNC_STAGES == 1) begin
            st_d.chain[0] = async_i;
        end else begin
            st_d.chain = {st_q.chain[SYNC_STAGES-2:0], async_i};
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign sync_o = st_q.chain[SYNC_STAGES-1];

endmodule

// File: rtl/oe_decode.sv
module oe_decode
    import clkoe_pkg::*;
#(
    parameter int N_OUT = 4
) (
    input  logic               rst,
    input  logic               glb_hiz_i,
    input  logic               sec_a_n_i,
    input  logic               sec_b_n_i,
    input  logic [2*N_OUT-1:0] cfg_mode_i,
    output logic [N_OUT-1:0]   drv_en_o
);
    logic allow;
    assign allow = ~rst & ~glb_hiz_i;

    for (genvar i = 0; i < N_OUT; i++) begin : g_out
        oe_mode_e mode;
        logic     sel;
        assign mode = oe_mode_e'(cfg_mode_i[2*i +: 2]);

        always_comb begin
            unique case (mode)
                OE_OFF:   sel = 1'b0;
                OE_ON:    sel = 1'b1;
                OE_SEC_A: sel = ~sec_a_n_i;
                OE_SEC_B: sel = ~sec_b_n_i;
                default:  sel = 1'b0;
            endcase
        end

        assign drv_en_o[i] = allow & sel;
    end

endmodule

// File: rtl/gate_slice.sv
module gate_slice
    import clkoe_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic gate_open_i,
    input  logic participate_i,
    input  logic invert_i,
    output logic clk_o
);
    slice_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d.run = 1'b0;
        end else begin
            st_d.run = ~participate_i | gate_open_i;
        end
    end

    // Falling-edge update: run only changes while the clock is low.
    always_ff @(negedge clk) begin
        st_q <= st_d;
    end

    assign clk_o = (clk & st_q.run) ^ invert_i;

endmodule

// File: rtl/clkout_ctrl.sv
module clkout_ctrl
    import clkoe_pkg::*;
#(
    parameter int N_OUT       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk_src,
    input  logic               rst,
    input  logic               glb_hiz_i,
    input  logic               sec_a_n_i,
    input  logic               sec_b_n_i,
    input  logic               gate_n_i,
    input  logic [2*N_OUT-1:0] cfg_mode_i,
    input  logic [N_OUT-1:0]   cfg_inv_i,
    input  logic [N_OUT-1:0]   cfg_gate_en_i,
    output logic [N_OUT-1:0]   clk_o,
    output logic [N_OUT-1:0]   drv_en_o,
    output logic               lock_loss_o
);
    logic gate_open;

    gate_synchronizer #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk_src),
        .rst     (rst),
        .async_i (gate_n_i),
        .sync_o  (gate_open)
    );

    oe_decode #(.N_OUT(N_OUT)) u_dec (
        .rst        (rst),
        .glb_hiz_i  (glb_hiz_i),
        .sec_a_n_i  (sec_a_n_i),
        .sec_b_n_i  (sec_b_n_i),
        .cfg_mode_i (cfg_mode_i),
        .drv_en_o   (drv_en_o)
    );

    for (genvar i = 0; i < N_OUT; i++) begin : g_slice
        gate_slice u_slice (
            .clk           (clk_src),
            .rst           (rst),
            .gate_open_i   (gate_open),
            .participate_i (cfg_gate_en_i[i]),
            .invert_i      (cfg_inv_i[i]),
            .clk_o         (clk_o[i])
        );
    end

    assign lock_loss_o = glb_hiz_i;

endmodule

// File: rtl/clkout_ctrl_chk.sv
module clkout_ctrl_chk #(
    parameter int N_OUT = 4
) (
    input logic               clk_src,
    input logic               rst,
    input logic               glb_hiz_i,
    input logic               sec_a_n_i,
    input logic               sec_b_n_i,
    input logic               gate_n_i,
    input logic [2*N_OUT-1:0] cfg_mode_i,
    input logic [N_OUT-1:0]   cfg_inv_i,
    input logic [N_OUT-1:0]   cfg_gate_en_i,
    input logic [N_OUT-1:0]   clk_o,
    input logic [N_OUT-1:0]   drv_en_o,
    input logic               lock_loss_o
);
    logic unused_ok;
    assign unused_ok = gate_n_i;

    AST_GLOBAL_HIZ: assert property (@(posedge clk_src) disable iff (rst)
        glb_hiz_i |-> (drv_en_o == '0)); // R1

    AST_LOCK_FLAG: assert property (@(posedge clk_src) disable iff (rst)
        $rose(glb_hiz_i) |-> lock_loss_o); // R6

    AST_GATE_NO_HIZ: assert property (@(posedge clk_src) disable iff (rst)
        (!$past(rst) && $stable(glb_hiz_i) && $stable(sec_a_n_i) && $stable(sec_b_n_i)
         && $stable(cfg_mode_i)) |-> $stable(drv_en_o)); // R7

    for (genvar i = 0; i < N_OUT; i++) begin : g_chk
        AST_OFF_MODE: assert property (@(posedge clk_src) disable iff (rst)
            (cfg_mode_i[2*i +: 2] == 2'b00) |-> !drv_en_o[i]); // R2

        AST_FREE_RUN: assert property (@(negedge clk_src) disable iff (rst)
            (!$past(rst) && !cfg_gate_en_i[i] && $stable(cfg_gate_en_i[i]))
            |-> (clk_o[i] == !cfg_inv_i[i])); // R9
    end

endmodule

bind clkout_ctrl clkout_ctrl_chk #(.N_OUT(N_OUT)) u_chk (
    .clk_src       (clk_src),
    .rst           (rst),
    .glb_hiz_i     (glb_hiz_i),
    .sec_a_n_i     (sec_a_n_i),
    .sec_b_n_i     (sec_b_n_i),
    .gate_n_i      (gate_n_i),
    .cfg_mode_i    (cfg_mode_i),
    .cfg_inv_i     (cfg_inv_i),
    .cfg_gate_en_i (cfg_gate_en_i),
    .clk_o         (clk_o),
    .drv_en_o      (drv_en_o),
    .lock_loss_o   (lock_loss_o)
);

// File: tb/clkout_ctrl_test.sv
`timescale 1ns/1ps
module clkout_ctrl_test;
    localparam int N = 4;

    logic         clk_src = 1'b0;
    logic         rst = 1'b1;
    logic         glb_hiz_i = 1'b0;
    logic         sec_a_n_i = 1'b0;
    logic         sec_b_n_i = 1'b0;
    logic         gate_n_i = 1'b1;
    logic [2*N-1:0] cfg_mode_i = 8'b01010101;
    logic [N-1:0] cfg_inv_i = 4'b1010;
    logic [N-1:0] cfg_gate_en_i = 4'b0011;
    logic [N-1:0] clk_o;
    logic [N-1:0] drv_en_o;
    logic         lock_loss_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk_src = ~clk_src;

    clkout_ctrl #(.N_OUT(N)) uut (
        .clk_src(clk_src), .rst(rst), .glb_hiz_i(glb_hiz_i),
        .sec_a_n_i(sec_a_n_i), .sec_b_n_i(sec_b_n_i), .gate_n_i(gate_n_i),
        .cfg_mode_i(cfg_mode_i), .cfg_inv_i(cfg_inv_i),
        .cfg_gate_en_i(cfg_gate_en_i), .clk_o(clk_o),
        .drv_en_o(drv_en_o), .lock_loss_o(lock_loss_o)
    );

    // {glb, sec_a_n, sec_b_n, modes[7:0], expected drv_en[3:0]}
    localparam logic [14:0] VEC [10] = '{
        {3'b000, 8'b11100100, 4'b1110},
        {3'b010, 8'b11100100, 4'b1010},
        {3'b001, 8'b11100100, 4'b0110},
        {3'b011, 8'b11100100, 4'b0010},
        {3'b100, 8'b11100100, 4'b0000},
        {3'b111, 8'b11100100, 4'b0000},
        {3'b011, 8'b01010101, 4'b1111},
        {3'b100, 8'b01010101, 4'b0000},
        {3'b000, 8'b00000000, 4'b0000},
        {3'b001, 8'b10101111, 4'b1100}
    };

    task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic hi();
        @(posedge clk_src); #2;
    endtask

    task automatic lo();
        @(negedge clk_src); #2;
    endtask

    initial begin
        // R10: reset state
        hi(); chk("R10 drv_en in reset", drv_en_o, 4'b0000);
        chk("R10 idle level high phase", clk_o, 4'b1010);
        lo(); chk("R10 idle level low phase", clk_o, 4'b1010);
        @(posedge clk_src); #1 rst = 1'b0;

        // R1..R6 table walk
        for (int k = 0; k < 10; k++) begin
            {glb_hiz_i, sec_a_n_i, sec_b_n_i, cfg_mode_i} = VEC[k][14:4];
            #1;
            chk("R1/R2/R3/R4/R5 enable decode", drv_en_o, VEC[k][3:0]);
            chk("R6 lock loss flag", {3'b000, lock_loss_o}, {3'b000, VEC[k][14]});
            @(posedge clk_src); #1;
        end

        glb_hiz_i = 1'b0; sec_a_n_i = 1'b0; sec_b_n_i = 1'b0; cfg_mode_i = 8'b01010101;
        repeat (3) @(posedge clk_src);
        hi(); chk("R9 running high phase", clk_o, 4'b0101);
        lo(); chk("R9 running low phase", clk_o, 4'b1010);

        // R8 stop: request just after a rising edge
        @(posedge clk_src); #1 gate_n_i = 1'b0;
        hi(); chk("R8 first edge still running", clk_o, 4'b0101);
        hi(); chk("R8 full high phase completes", clk_o, 4'b0101);
        lo(); chk("R8 low after stop", clk_o, 4'b1010);
        hi(); chk("R7 gated levels high phase", clk_o, 4'b0110);
        chk("R7 gating keeps drivers on", drv_en_o, 4'b1111);
        lo(); chk("R7 gated levels low phase", clk_o, 4'b1010);

        // Overlap: global override while gated
        #1 glb_hiz_i = 1'b1; #1;
        chk("R1 override while gated", drv_en_o, 4'b0000);
        chk("R6 lock loss while gated", {3'b000, lock_loss_o}, 4'b0001);
        hi(); chk("R7 gated data kept under override", clk_o, 4'b0110);
        #1 glb_hiz_i = 1'b0; #1;
        chk("R3 enables back after override", drv_en_o, 4'b1111);

        // R8 restart
        @(posedge clk_src); #1 gate_n_i = 1'b1;
        hi(); chk("R8 restart first edge still gated", clk_o, 4'b0110);
        hi(); chk("R8 restart second edge still gated", clk_o, 4'b0110);
        lo(); chk("R8 restart low phase", clk_o, 4'b1010);
        hi(); chk("R8 restart full high phase", clk_o, 4'b0101);

        // R10: reset during operation
        @(posedge clk_src); #1 rst = 1'b1; #1;
        chk("R10 drivers off at reset", drv_en_o, 4'b0000);
        lo(); hi(); chk("R10 idle after reset", clk_o, 4'b1010);
        #1 rst = 1'b0;
        hi(); chk("R10 gated outputs wait for sync", clk_o, 4'b0110);
        hi(); lo(); hi(); chk("R10 gated outputs start after sync", clk_o, 4'b0101);
        chk("R10 drivers on after reset", drv_en_o, 4'b1111);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule